// File: doc/BRIEF.md
# Packet-Offset Byte Pattern Matcher

This block watches a packet stream carried eight bytes per beat, each packet framed by a start marker and an end marker. It decides whether a configured sequence of up to eight bytes, with a per-byte compare enable, sits at a configured byte offset from the first byte of the packet. The verdict is delivered on a flag that rises together with the start marker of the same packet as it leaves the block. A downstream consumer therefore knows the outcome before it sees any of the packet.

The verdict must exist before the packet is released. To make that possible, every beat with its markers is held in a delay line sixteen beats deep, which covers the whole search window. A small tracker runs on the input side, follows the beat index inside the current packet and folds in the byte comparisons. At the last beat the pattern can touch, the tracker writes its result into the delay-line stage that holds that packet's start beat. Pattern, mask and offset are static configuration, held steady while traffic flows.

The stream interface has a valid qualifier and no ready signal: the block never applies back-pressure. A cycle with `in_valid` low is a bubble. It moves nothing forward, and the output shows a bubble in the following cycle.

Top module: `pkt_offset_matcher`

## Requirements
- R1: Each accepted beat (`in_valid` high) appears on `out_data`/`out_sop`/`out_eop` with `out_valid` high in the cycle right after the clock edge at which the 16th later beat is accepted. Beats leave in order. No beat is output before 17 have been accepted.
- R2: A cycle with `in_valid` low leaves the delay line unchanged, and `out_valid` is low in the next cycle.
- R3: Packet byte b is carried in beat b/8 of the packet, the beat with the start marker being beat 0, on bits [63-8*(b%8) -: 8]. Pattern byte k is `cfg_pattern[63-8k -: 8]` and is compared with packet byte `cfg_offset`+k. The offset ranges from 0 to 120.
- R4: Pattern byte k takes part in the comparison only when `cfg_mask[k]` is 1. A cleared mask bit makes that byte don't-care. A mask of all zeros matches every packet that is long enough.
- R5: `out_match` is high only in a cycle where `out_valid` and `out_sop` are both high. It is 1 exactly when the packet starting on that beat matched, and 0 on every other output cycle.
- R6: A packet whose end marker arrives on a beat with index below (`cfg_offset`+7)/8 is reported with `out_match` 0, whatever its bytes hold.
- R7: A pattern whose bytes straddle two beats is matched correctly, comparing bytes from both beats.
- R8: A start marker that arrives while a packet is still open, with no end marker seen, closes the old packet and begins a new one. The old packet's verdict covers only the beats it received.
- R9: While `rst` is high and in the first cycle after it, `out_valid`, `out_sop`, `out_eop` and `out_match` are 0, and the delay line is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_offset | input | 7 | Byte offset of pattern byte 0 from the packet start |
| cfg_pattern | input | 64 | Pattern bytes, byte 0 in the top bits |
| cfg_mask | input | 8 | Per-byte compare enable, bit k for pattern byte k |
| in_valid | input | 1 | Input beat present |
| in_data | input | 64 | Input beat, byte 0 in bits [63:56] |
| in_sop | input | 1 | Input beat starts a packet |
| in_eop | input | 1 | Input beat ends a packet |
| out_valid | output | 1 | Output beat present |
| out_data | output | 64 | Delayed beat |
| out_sop | output | 1 | Delayed start marker |
| out_eop | output | 1 | Delayed end marker |
| out_match | output | 1 | Verdict for the packet that starts on this output beat |

## Verification
The bench targets several places where the verdict can end up on the wrong beat or the wrong packet:
- Bubbles placed between beats: a design that advanced on every clock would drift out of step with the expected release schedule.
- Offsets that put the pattern across a beat boundary, and the deepest offset of 120: a wrong lane or beat computation would report matches on the wrong bytes, or drop the verdict written into the last stage.
- Packets shorter than the window, including back-to-back one-beat packets: a tracker that kept comparing past the end marker would raise false matches.
- Start markers with no end marker before them, and masks with bytes cleared: these show whether the old packet is abandoned cleanly and whether don't-care bytes are really ignored.

// File: rtl/pm_pkg.sv
package pm_pkg;
  // control bits carried beside each beat in the delay line
  typedef struct packed {
    logic v;    // stage holds a beat
    logic sop;  // beat starts a packet
    logic eop;  // beat ends a packet
    logic m;    // verdict, only meaningful on a start beat
  } pm_ctl_t;
endpackage

// File: rtl/pm_lane_cmp.sv
module pm_lane_cmp #(
  parameter int BYTES = 8,
  parameter int IDX_W = 5,
  parameter int OFS_W = 7
) (
  input  logic [BYTES*8-1:0] beat_data,
  input  logic [IDX_W-1:0]   beat_idx,
  input  logic [OFS_W-1:0]   cfg_offset,
  input  logic [BYTES*8-1:0] cfg_pattern,
  input  logic [BYTES-1:0]   cfg_mask,
  output logic               beat_ok
);
  localparam int LANE_W = $clog2(BYTES);

  logic [BYTES-1:0] bad;

  for (genvar k = 0; k < BYTES; k++) begin : g_byte
    logic [OFS_W:0]    pos;
    logic [LANE_W-1:0] lane;
    logic              here;
    logic [7:0]        got;
    assign pos  = {1'b0, cfg_offset} + (OFS_W+1)'(k);
    assign lane = pos[LANE_W-1:0];
    assign here = cfg_mask[k] && (IDX_W'(pos >> LANE_W) == beat_idx);
    assign got  = beat_data[8*(BYTES-1-int'(lane)) +: 8];
    assign bad[k] = here && (got != cfg_pattern[8*(BYTES-1-k) +: 8]);
  end

  assign beat_ok = ~|bad;

  always_comb begin
    if (cfg_mask == '0) begin
      assert_mask_clear_R4: assert (beat_ok)
        else $error("cleared mask still rejected a beat");
    end
  end
endmodule

// File: rtl/pm_tracker.sv
module pm_tracker #(
  parameter int BYTES = 8,
  parameter int DEPTH = 16,
  parameter int IDX_W = 5,
  parameter int OFS_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [OFS_W-1:0] cfg_offset,
  input  logic             beat_ok,
  output logic [IDX_W-1:0] cur_idx,
  output logic [IDX_W-1:0] end_beat,
  output logic             decide,
  output logic             verdict
);
  localparam int LANE_W = $clog2(BYTES);

  logic [IDX_W-1:0] idx_q;
  logic             active_q;
  logic             ok_q;
  logic             in_pkt;
  logic [OFS_W:0]   last_pos;

  assign last_pos = {1'b0, cfg_offset} + (OFS_W+1)'(BYTES-1);
  assign end_beat = IDX_W'(last_pos >> LANE_W);
  assign in_pkt   = in_sop || active_q;
  assign cur_idx  = in_sop ? '0 : idx_q;
  assign verdict  = (in_sop ? 1'b1 : ok_q) && beat_ok;
  assign decide   = in_valid && in_pkt && (cur_idx == end_beat);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      active_q <= 1'b0;
      ok_q     <= 1'b1;
    end else if (in_valid) begin
      active_q <= in_pkt && !in_eop;
      idx_q    <= (cur_idx == IDX_W'(DEPTH)) ? IDX_W'(DEPTH) : cur_idx + 1'b1;
      ok_q     <= verdict;
    end
  end

  // a beat outside any packet (after an end marker, before a start) never yields a verdict
  assert_no_verdict_outside_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_sop && !active_q) |-> !decide);
endmodule

// File: rtl/pm_delay_line.sv
module pm_delay_line
  import pm_pkg::*;
#(
  parameter int W     = 64,
  parameter int DEPTH = 16,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [W-1:0]     in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic             decide,
  input  logic [IDX_W-1:0] dec_stage,
  input  logic             verdict,
  output logic             out_valid,
  output logic [W-1:0]     out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic             out_match
);
  logic [W-1:0] st_d [DEPTH];
  pm_ctl_t      st_c [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_stage
    logic [W-1:0] prev_d;
    pm_ctl_t      prev_c;
    if (j == 0) begin : g_head
      assign prev_d = in_data;
      assign prev_c = '{v: 1'b1, sop: in_sop, eop: in_eop, m: 1'b0};
    end else begin : g_body
      assign prev_d = st_d[j-1];
      assign prev_c = st_c[j-1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        st_c[j] <= '0;
      end else if (adv) begin
        st_c[j].v   <= prev_c.v;
        st_c[j].sop <= prev_c.sop;
        st_c[j].eop <= prev_c.eop;
        st_c[j].m   <= (decide && dec_stage == IDX_W'(j)) ? verdict : prev_c.m;
      end
    end

    always_ff @(posedge clk) begin
      if (adv) st_d[j] <= prev_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_match <= 1'b0;
    end else begin
      out_valid <= adv && st_c[DEPTH-1].v;
      out_sop   <= adv && st_c[DEPTH-1].v && st_c[DEPTH-1].sop;
      out_eop   <= adv && st_c[DEPTH-1].v && st_c[DEPTH-1].eop;
      out_match <= adv && st_c[DEPTH-1].v && st_c[DEPTH-1].sop && st_c[DEPTH-1].m;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) out_data <= st_d[DEPTH-1];
  end

  assert_gap_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !adv |=> !out_valid);

  assert_flag_on_sop_R5: assert property (@(posedge clk) disable iff (rst)
    out_match |-> (out_sop && out_valid));
endmodule

// File: rtl/pkt_offset_matcher.sv
module pkt_offset_matcher #(
  parameter int BYTES = 8,
  parameter int DEPTH = 16,
  localparam int W     = BYTES * 8,
  localparam int OFS_W = $clog2(DEPTH * BYTES),
  localparam int IDX_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OFS_W-1:0] cfg_offset,
  input  logic [W-1:0]     cfg_pattern,
  input  logic [BYTES-1:0] cfg_mask,
  input  logic             in_valid,
  input  logic [W-1:0]     in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  output logic             out_valid,
  output logic [W-1:0]     out_data,
  output logic             out_sop,
  output logic             out_eop,
  output logic             out_match
);
  logic [IDX_W-1:0] cur_idx;
  logic [IDX_W-1:0] end_beat;
  logic             beat_ok;
  logic             decide;
  logic             verdict;

  pm_lane_cmp #(.BYTES(BYTES), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_cmp (
    .beat_data  (in_data),
    .beat_idx   (cur_idx),
    .cfg_offset (cfg_offset),
    .cfg_pattern(cfg_pattern),
    .cfg_mask   (cfg_mask),
    .beat_ok    (beat_ok)
  );

  pm_tracker #(.BYTES(BYTES), .DEPTH(DEPTH), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_trk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .cfg_offset(cfg_offset),
    .beat_ok   (beat_ok),
    .cur_idx   (cur_idx),
    .end_beat  (end_beat),
    .decide    (decide),
    .verdict   (verdict)
  );

  pm_delay_line #(.W(W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_dly (
    .clk      (clk),
    .rst      (rst),
    .adv      (in_valid),
    .in_data  (in_data),
    .in_sop   (in_sop),
    .in_eop   (in_eop),
    .decide   (decide),
    .dec_stage(end_beat),
    .verdict  (verdict),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_sop  (out_sop),
    .out_eop  (out_eop),
    .out_match(out_match)
  );
endmodule

// File: tb/pkt_offset_matcher_tb.sv
module pkt_offset_matcher_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 16;
  localparam int MAXB = 2048;

  logic        clk = 1'b0;
  logic        rst;
  logic [6:0]  cfg_offset;
  logic [63:0] cfg_pattern;
  logic [7:0]  cfg_mask;
  logic        in_valid, in_sop, in_eop;
  logic [63:0] in_data;
  logic        out_valid, out_sop, out_eop, out_match;
  logic [63:0] out_data;

  int checks = 0;
  int fails  = 0;

  logic [63:0] bd [MAXB];
  logic        bs [MAXB];
  logic        be [MAXB];
  logic        bm [MAXB];
  int          nb;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_offset_matcher u_dut (
    .clk(clk), .rst(rst), .cfg_offset(cfg_offset), .cfg_pattern(cfg_pattern),
    .cfg_mask(cfg_mask), .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop),
    .in_eop(in_eop), .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .out_match(out_match)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pkt_byte(int start, int b);
    return bd[start + b/8][63-8*(b%8) -: 8];
  endfunction

  // verdict from the requirements: long enough (R6) and all enabled bytes equal (R3, R4)
  function automatic logic exp_match(int start, int len);
    int last_beat = (int'(cfg_offset) + 7) / 8;
    if (len <= last_beat) return 1'b0;
    for (int k = 0; k < 8; k++)
      if (cfg_mask[k] && pkt_byte(start, int'(cfg_offset) + k) != cfg_pattern[63-8*k -: 8])
        return 1'b0;
    return 1'b1;
  endfunction

  task automatic do_reset();
    in_valid = 0; in_sop = 0; in_eop = 0; in_data = '0;
    rst = 1;
    repeat (2) @(posedge clk);
    #1;
    chk("R9 out_valid in reset", 64'(out_valid), 64'd0);
    chk("R9 out_match in reset", 64'(out_match), 64'd0);
    @(negedge clk);
    rst = 0;
    @(posedge clk); #1;
    chk("R9 out_valid after reset", 64'(out_valid), 64'd0);
    chk("R9 out_sop after reset", 64'(out_sop), 64'd0);
  endtask

  // build the beat list: npk packets of minl..maxl beats
  task automatic build(int npk, int minl, int maxl, bit drop_eop);
    int starts [64];
    int lens [64];
    nb = 0;
    for (int p = 0; p < npk; p++) begin
      int len = minl + int'($urandom_range(maxl - minl));
      starts[p] = nb;
      lens[p] = len;
      for (int i = 0; i < len; i++) begin
        bd[nb+i] = {$urandom, $urandom};
        bs[nb+i] = (i == 0);
        be[nb+i] = (i == len - 1);
        bm[nb+i] = 1'b0;
      end
      if ($urandom_range(3) != 0) begin
        for (int k = 0; k < 8; k++) begin
          int b = int'(cfg_offset) + k;
          if (b / 8 < len) bd[nb + b/8][63-8*(b%8) -: 8] = cfg_pattern[63-8*k -: 8];
        end
        if ($urandom_range(3) == 0) begin
          int b = int'(cfg_offset) + int'($urandom_range(7));
          if (b / 8 < len) bd[nb + b/8][63-8*(b%8) -: 8] ^= 8'h5a;
        end
      end
      if (drop_eop && p < npk - 1 && $urandom_range(1) == 1) be[nb+len-1] = 1'b0;
      nb += len;
    end
    for (int p = 0; p < npk; p++) bm[starts[p]] = exp_match(starts[p], lens[p]);
    // trailing flush packet so the last real beats drain out
    for (int i = 0; i < LAT; i++) begin
      bd[nb+i] = {$urandom, $urandom};
      bs[nb+i] = (i == 0);
      be[nb+i] = (i == LAT - 1);
      bm[nb+i] = 1'b0;
    end
    nb += LAT;
  endtask

  task automatic drive(string tag, int gap_pct);
    for (int i = 0; i < nb; i++) begin
      while (int'($urandom_range(99)) < gap_pct) begin
        @(negedge clk);
        in_valid = 0; in_sop = $urandom_range(1); in_eop = $urandom_range(1);
        in_data = {$urandom, $urandom};
        @(posedge clk); #1;
        chk("R2 out_valid after bubble", 64'(out_valid), 64'd0);
      end
      @(negedge clk);
      in_valid = 1; in_data = bd[i]; in_sop = bs[i]; in_eop = be[i];
      @(posedge clk); #1;
      if (i < LAT) begin
        chk("R1 no output while filling", 64'(out_valid), 64'd0);
      end else begin
        int j = i - LAT;
        chk("R1 out_valid", 64'(out_valid), 64'd1);
        chk("R1 out_data", out_data, bd[j]);
        chk("R1 out_sop", 64'(out_sop), 64'(bs[j]));
        chk("R1 out_eop", 64'(out_eop), 64'(be[j]));
        if (bs[j]) chk(tag, 64'(out_match), 64'(bm[j]));
        else       chk("R5 match off non-start beat", 64'(out_match), 64'd0);
      end
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic scenario(string tag, logic [6:0] off, logic [7:0] msk,
                          int npk, int minl, int maxl, bit drop_eop, int gap_pct);
    cfg_offset = off;
    cfg_mask = msk;
    cfg_pattern = {$urandom, $urandom};
    do_reset();
    build(npk, minl, maxl, drop_eop);
    drive(tag, gap_pct);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    cfg_offset = '0; cfg_mask = '0; cfg_pattern = '0;
    scenario("R3 match at offset 0", 7'd0, 8'hff, 30, 1, 6, 1'b0, 0);
    scenario("R7 straddling pattern", 7'd13, 8'hff, 30, 1, 6, 1'b0, 20);
    scenario("R4 partial mask", 7'd21, 8'ha5, 30, 2, 8, 1'b0, 10);
    scenario("R4 empty mask", 7'd60, 8'h00, 20, 5, 12, 1'b0, 0);
    scenario("R6 deep offset short packets", 7'd120, 8'hff, 30, 1, 18, 1'b0, 15);
    scenario("R8 start without end", 7'd9, 8'hff, 40, 1, 5, 1'b1, 10);
    for (int r = 0; r < 6; r++)
      scenario("R5 random config", 7'($urandom_range(120)), 8'($urandom),
               30, 1, 18, 1'b1, 25);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule